// File: doc/BRIEF.md
# Length-Bounded Vector Rotate Unit

This unit rotates the leading part of a vector register toward lane zero by a signed scalar count. The caller presents a packed vector of `LANES` elements, each `DW` bits wide, together with a signed rotate count and an active length. Only the lanes below the active length take part. They form a ring of that length, and the count wraps within that ring rather than across the whole register. Lanes at or above the active length leave the unit unchanged.

A negative count is brought into range by taking its signed remainder by the active length and adding the length when that remainder is below zero. An active length of zero leaves the vector untouched, and no remainder by zero is ever formed. An active length larger than `LANES` is treated as `LANES`. The result is registered: a valid strobe on the input produces a valid result one clock later. The registered vector holds its value between results.

Top module: `vrot_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` in any cycle equals the value `in_valid` had at the preceding rising clock edge.
- R3: Let L be the clamped active length, with 1 <= L, and let k be the effective count, with 0 <= k < L. For each lane j < L, output lane j equals input lane (j + k) mod L. Lane j occupies bits [j*DW +: DW] of both vectors.
- R4: The effective count is the signed remainder of `in_amt` by L (truncated toward zero), plus L when that remainder is negative. For example, -1 with L = 5 gives k = 4, and -13 with L = 5 gives k = 2.
- R5: Each lane j with j >= L is output equal to input lane j.
- R6: When the active length is 0, `out_vec` equals `in_vec` for any count.
- R7: When L = 1, or when the effective count is 0, `out_vec` equals `in_vec`.
- R8: An `in_len` greater than `LANES` behaves exactly as `in_len` = `LANES`.
- R9: In a cycle after `in_valid` was low at the clock edge, `out_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands below are valid this cycle |
| in_vec | input | LANES*DW | Packed source vector, lane j at bits [j*DW +: DW] |
| in_amt | input | AMT_W | Signed rotate count, two's complement |
| in_len | input | LEN_IN_W | Active length, clamped to LANES |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | LANES*DW | Registered rotated vector |

## Verification
The two functions that can meet in one operation are clamping of an oversized length and normalization of a negative count. Only after the clamp does the modulus that folds the count exist, so an error in either step gives a wrong rotation. The bench therefore sends operations with lengths above `LANES` and negative counts at the same time, including the most negative count. It also sends back-to-back valid operations, so that one operation is captured in the same cycle that the previous result is presented. A behavioural reference model updates on every clock, and every output cycle is compared against it. A directed lane check pins the expected wrap values independently of the model.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
   // bits needed to hold a count from 0 up to and including n
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // bits needed to index n lanes
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/vrot_len_clamp.sv
module vrot_len_clamp #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned LEN_IN_W = 8,
   parameter int unsigned LW       = 4
) (
   input  logic [LEN_IN_W-1:0] len_raw,
   output logic [LW-1:0]       len_eff
);
   localparam int unsigned CW = (LEN_IN_W > LW) ? LEN_IN_W : LW;
   localparam logic [CW-1:0] LIMIT = CW'(LANES);

   logic [CW-1:0] len_wide;

   assign len_wide = CW'(len_raw);

   always_comb begin
      if (len_wide > LIMIT) len_eff = LW'(LANES);
      else                  len_eff = LW'(len_wide);
   end
endmodule

// File: rtl/vrot_amt_norm.sv
module vrot_amt_norm #(
   parameter int unsigned LANES = 8,
   parameter int unsigned AMT_W = 32,
   parameter int unsigned LW    = 4
) (
   input  logic signed [AMT_W-1:0] amt,
   input  logic [LW-1:0]           len_eff,
   output logic [LW-1:0]           shift
);
   logic [LW-1:0] shift_tab [LANES+1];

   assign shift_tab[0] = '0;

   // one constant-divisor remainder per possible active length
   for (genvar l = 1; l <= LANES; l++) begin : g_len
      localparam logic signed [AMT_W-1:0] DIV = AMT_W'(l);
      logic signed [AMT_W-1:0] rem;
      logic signed [AMT_W-1:0] pos;
      assign rem = amt % DIV;
      assign pos = (rem < 0) ? (rem + DIV) : rem;
      assign shift_tab[l] = LW'(pos);
   end

   always_comb begin
      shift = '0;
      for (int unsigned i = 1; i <= LANES; i++) begin
         if (len_eff == LW'(i)) shift = shift_tab[i];
      end
   end
endmodule

// File: rtl/vrot_lane_sel.sv
module vrot_lane_sel #(
   parameter int unsigned LANES = 8,
   parameter int unsigned DW    = 32,
   parameter int unsigned LW    = 4,
   parameter int unsigned IW    = 3
) (
   input  logic [LANES*DW-1:0] vec_in,
   input  logic [LW-1:0]       len_eff,
   input  logic [LW-1:0]       shift,
   output logic [LANES*DW-1:0] vec_out
);
   logic [DW-1:0] lanes [LANES];

   for (genvar s = 0; s < LANES; s++) begin : g_unpack
      assign lanes[s] = vec_in[s*DW +: DW];
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LW:0] sum;
      logic [LW:0] src;
      logic        active;

      assign sum    = {1'b0, shift} + (LW+1)'(j);
      assign src    = (sum >= {1'b0, len_eff}) ? (sum - {1'b0, len_eff}) : sum;
      assign active = (LW'(j) < len_eff);
      assign vec_out[j*DW +: DW] = active ? lanes[IW'(src)] : lanes[j];
   end
endmodule

// File: rtl/vrot_unit.sv
module vrot_unit #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned DW       = 32,
   parameter int unsigned AMT_W    = 32,
   parameter int unsigned LEN_IN_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [LANES*DW-1:0]     in_vec,
   input  logic signed [AMT_W-1:0] in_amt,
   input  logic [LEN_IN_W-1:0]     in_len,
   output logic                    out_valid,
   output logic [LANES*DW-1:0]     out_vec
);
   import vrot_pkg::*;

   localparam int unsigned LW = cnt_bits(LANES);
   localparam int unsigned IW = idx_bits(LANES);

   // elaboration-time parameter checks
   if (LANES < 2) begin : g_bad_lanes
      $error("vrot_unit: LANES must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("vrot_unit: DW must be at least 1");
   end
   if (AMT_W <= LW) begin : g_bad_amt
      $error("vrot_unit: AMT_W must exceed the length field width");
   end
   if (LEN_IN_W < LW) begin : g_bad_len
      $error("vrot_unit: LEN_IN_W too narrow to express LANES");
   end

   logic [LW-1:0]       len_eff;
   logic [LW-1:0]       shift;
   logic [LANES*DW-1:0] rot_vec;

   vrot_len_clamp #(
      .LANES(LANES), .LEN_IN_W(LEN_IN_W), .LW(LW)
   ) u_clamp (
      .len_raw (in_len),
      .len_eff (len_eff)
   );

   vrot_amt_norm #(
      .LANES(LANES), .AMT_W(AMT_W), .LW(LW)
   ) u_norm (
      .amt     (in_amt),
      .len_eff (len_eff),
      .shift   (shift)
   );

   vrot_lane_sel #(
      .LANES(LANES), .DW(DW), .LW(LW), .IW(IW)
   ) u_sel (
      .vec_in  (in_vec),
      .len_eff (len_eff),
      .shift   (shift),
      .vec_out (rot_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_vec <= rot_vec;
      end
   end
endmodule

// File: rtl/vrot_unit_chk.sv
module vrot_unit_chk #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned DW       = 32,
   parameter int unsigned AMT_W    = 32,
   parameter int unsigned LEN_IN_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [LANES*DW-1:0]     in_vec,
   input logic signed [AMT_W-1:0] in_amt,
   input logic [LEN_IN_W-1:0]     in_len,
   input logic                    out_valid,
   input logic [LANES*DW-1:0]     out_vec
);
   localparam int unsigned TOP = LANES - 1;

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_vec));

   assert_zero_len_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(in_len) == '0))
      |-> (out_vec == $past(in_vec)));

   assert_unit_len_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) &&
       (($past(in_len) == LEN_IN_W'(1)) || ($past(in_amt) == '0)))
      |-> (out_vec == $past(in_vec)));

   assert_tail_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(in_len) < LEN_IN_W'(LANES)))
      |-> (out_vec[TOP*DW +: DW] == $past(in_vec[TOP*DW +: DW])));
endmodule

bind vrot_unit vrot_unit_chk #(
   .LANES(LANES), .DW(DW), .AMT_W(AMT_W), .LEN_IN_W(LEN_IN_W)
) u_chk (.*);

// File: tb/vrot_unit_tb.sv
module vrot_unit_tb;
   localparam int unsigned LANES    = 8;
   localparam int unsigned DW       = 32;
   localparam int unsigned AMT_W    = 32;
   localparam int unsigned LEN_IN_W = 8;
   localparam int unsigned W        = LANES * DW;
   localparam time         CLK_PERIOD = 10ns;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic [W-1:0]            in_vec = '0;
   logic signed [AMT_W-1:0] in_amt = '0;
   logic [LEN_IN_W-1:0]     in_len = '0;
   logic                    out_valid;
   logic [W-1:0]            out_vec;

   int checks = 0;
   int failures = 0;
   bit cmp_en = 1'b0;
   string cur_tag = "R1";

   logic         exp_valid = 1'b0;
   logic [W-1:0] exp_vec = '0;
   string        exp_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   vrot_unit #(
      .LANES(LANES), .DW(DW), .AMT_W(AMT_W), .LEN_IN_W(LEN_IN_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
      .in_amt(in_amt), .in_len(in_len), .out_valid(out_valid), .out_vec(out_vec)
   );

   function automatic logic [W-1:0] ref_rot(input logic [W-1:0] v, input int amt, input int len);
      logic [W-1:0] r;
      int L;
      int k;
      r = v;
      L = (len > int'(LANES)) ? int'(LANES) : len;
      if (L == 0) return v;
      k = amt % L;
      if (k < 0) k = k + L;
      for (int j = 0; j < L; j++) r[j*DW +: DW] = v[((j + k) % L)*DW +: DW];
      return r;
   endfunction

   // reference model, advanced on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         exp_valid <= 1'b0;
         exp_vec   <= '0;
      end else begin
         exp_valid <= in_valid;
         if (in_valid) exp_vec <= ref_rot(in_vec, int'(in_amt), int'(in_len));
      end
      exp_tag <= cur_tag;
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         checks++;
         if (out_valid !== exp_valid || out_vec !== exp_vec) begin
            failures++;
            $display("FAIL %s: valid=%b vec=%h expected valid=%b vec=%h",
                     exp_tag, out_valid, out_vec, exp_valid, exp_vec);
         end
      end
   end

   task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ramp(input int base);
      logic [W-1:0] v;
      for (int j = 0; j < int'(LANES); j++) v[j*DW +: DW] = DW'(base + j);
      return v;
   endfunction

   // called at a negedge; result is visible at the following negedge
   task automatic send(input logic [W-1:0] v, input int amt, input int len, input string tag);
      cur_tag  = tag;
      in_valid = 1'b1;
      in_vec   = v;
      in_amt   = AMT_W'(amt);
      in_len   = LEN_IN_W'(len);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      cur_tag  = tag;
      in_valid = 1'b0;
      in_vec   = ~in_vec;
      in_amt   = in_amt + 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check_val("R1 reset valid", W'(out_valid), W'(0));
      check_val("R1 reset vec", out_vec, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R1 first cycle after reset", {out_vec[W-2:0], out_valid}, '0);
      cmp_en = 1'b1;

      v = ramp(32'hA0);
      send(v, 3, 8, "R3 full length");
      check_val("R3 lane0 full length", W'(out_vec[0 +: DW]), W'(32'hA3));
      send(v, 2, 5, "R3 partial length");
      check_val("R5 lane6 untouched", W'(out_vec[6*DW +: DW]), W'(32'hA6));
      send(v, -1, 5, "R4 count -1");
      check_val("R4 lane0 after -1", W'(out_vec[0 +: DW]), W'(32'hA4));
      check_val("R4 lane1 after -1", W'(out_vec[DW +: DW]), W'(32'hA0));
      send(v, -13, 5, "R4 count -13");
      check_val("R4 lane0 after -13", W'(out_vec[0 +: DW]), W'(32'hA2));
      send(v, 32'sh8000_0000, 7, "R4 most negative count");
      idle("R9 hold after result");
      held = out_vec;
      idle("R2 R9 second idle");
      check_val("R9 vec held", out_vec, held);
      check_val("R2 valid low", W'(out_valid), W'(0));

      send(v, 5, 0, "R6 zero length");
      check_val("R6 passthrough", out_vec, v);
      send(v, 9, 1, "R7 unit length");
      check_val("R7 unit length", out_vec, v);
      send(v, 12, 6, "R7 zero effective count");
      check_val("R7 zero effective count", out_vec, v);
      send(v, -3, 200, "R8 clamp with negative count");
      check_val("R8 lane0 clamp -3", W'(out_vec[0 +: DW]), W'(32'hA5));
      send(v, 1, 9, "R8 clamp len 9");
      check_val("R8 lane7 wraps", W'(out_vec[7*DW +: DW]), W'(32'hA0));

      for (int n = 0; n < 200; n++) begin
         logic [W-1:0] rv;
         for (int j = 0; j < int'(LANES); j++) rv[j*DW +: DW] = $urandom;
         if (n % 7 == 3) idle("R9 random gap");
         send(rv, int'($urandom), int'($urandom_range(0, 12)), "R3 R4 R8 random");
      end
      idle("R2 final");
      idle("R9 final");
      cmp_en = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule